// File: doc/BRIEF.md
# Column Context Transfer Controller

The block serves one column of a reconfigurable fabric. It moves task state between a few local context slots and the hidden plane of the column's serial scan chain. A supervisor sets a slot index, the tags of the outgoing task, the tags of the incoming task and a command through word-wide registers. The controller then performs the transfer one bit per clock.

A restore looks up the slots by task ID and expected version. It loads the hidden plane only on an exact match, and then asks the fabric to exchange its active and hidden planes. A save shifts the hidden plane out into the chosen slot and tags it with the supplied version. It then pushes the slot to a central repository through a request/acknowledge port. The slot stays marked dirty until that push is acknowledged.

A switch command chains a restore, the plane exchange and a save of the outgoing state. The running task's state therefore leaves only after the incoming state is already live.

Top module: `ctx_col_ctrl`

## Requirements
- R1: After reset the status reads 0, every slot info word reads 0, and `scan_shift_o`, `swap_req_o` and `wt_req_o` are low.
- R2: Register map: address 0 starts a command from bits [1:0] (1 restore, 2 save, 3 switch). Address 1 is the slot index, 2 the save task, 3 the save version, 4 the load task, 5 the load version. Address 6 reads status {wt_busy[4], miss[3], ver_err[2], done[1], busy[0]}. Address 7 reads the info of the indexed slot {dirty[9], valid[8], task[7:4], version[3:0]}. Every write made while a command is pending or running is ignored.
- R3: A restore that hits shifts for exactly CHAIN_LEN cycles, with slot bit 0 driven first on `scan_in_o`, so that the hidden plane equals the slot. It is followed by exactly one `swap_req_o` pulse.
- R4: A restore whose task ID matches a valid slot but whose version matches none sets ver_err and done, with no shift and no swap. This also covers a stale copy left behind after a newer save.
- R5: A restore whose task ID matches no valid slot sets miss and done, with no shift and no swap.
- R6: A save shifts the hidden plane out for CHAIN_LEN cycles, sampling `scan_out_i`, where the first bit out becomes bit 0. It stores the data in the indexed slot with the save task, the save version, valid=1 and dirty=1.
- R7: After a save, `wt_req_o` stays high with the task, version and data stable until `wt_ack_i`. The slot becomes clean only then, and done is set only then.
- R8: A switch performs the restore, then a single swap, then a save of the now-hidden outgoing state into the indexed slot, for 2*CHAIN_LEN shift cycles in total.
- R9: A switch whose lookup fails sets the error flag and done, and shifts, swaps, saves and pushes nothing.
- R10: A save or switch with a slot index of SLOTS or more is refused with miss set, and touches no slot and no port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data for bus_addr_i |
| scan_shift_o | output | 1 | Shift enable of the hidden-plane chain |
| scan_in_o | output | 1 | Serial data into the chain |
| scan_out_i | input | 1 | Serial data out of the chain |
| swap_req_o | output | 1 | One-cycle request to exchange the planes |
| wt_req_o | output | 1 | Write-through request to the central store |
| wt_task_o | output | TASK_W | Task ID of the pushed context |
| wt_ver_o | output | VER_W | Version of the pushed context |
| wt_data_o | output | CHAIN_LEN | Pushed context bits |
| wt_ack_i | input | 1 | Central store acknowledge |

## Verification
Faults in the slot tags or in the lookup show up at the next restore. Such a fault either loads the wrong pattern into the plane, which is visible in the plane contents after the swap, or it raises the wrong flag in status within two cycles of the start. A shift counter that is off by one leaves the chain rotated, so the restored plane or the pushed word mismatches at the end of the command. Ordering faults in a switch are visible as soon as it completes: the restored state is not active, or the pushed word is not the old active state. A dirty bit that clears too early or too late shows in the slot info word read while the acknowledge is held back.

// File: rtl/ctx_pkg.sv
`timescale 1ns/1ps
package ctx_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_LOAD   = 2'd1,
    CMD_SAVE   = 2'd2,
    CMD_SWITCH = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_IN, S_SWAP, S_OUT, S_WT
  } seq_st_e;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_SLOT  = 3'd1;
  localparam logic [2:0] A_STASK = 3'd2;
  localparam logic [2:0] A_SVER  = 3'd3;
  localparam logic [2:0] A_LTASK = 3'd4;
  localparam logic [2:0] A_LVER  = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;
  localparam logic [2:0] A_INFO  = 3'd7;

  localparam int STAT_W = 5;
endpackage

// File: rtl/ctx_regs.sv
`timescale 1ns/1ps
module ctx_regs
  import ctx_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int TASK_W = 4,
  parameter int VER_W  = 4,
  parameter int SLOT_W = 2,
  parameter int INFO_W = TASK_W + VER_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [INFO_W-1:0] info_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              start_o,
  output cmd_e              cmd_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [TASK_W-1:0] stask_o,
  output logic [VER_W-1:0]  sver_o,
  output logic [TASK_W-1:0] ltask_o,
  output logic [VER_W-1:0]  lver_o
);
  logic accept;
  assign accept = we_i && !busy_i && !start_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      cmd_o   <= CMD_NONE;
      slot_o  <= '0;
      stask_o <= '0;
      sver_o  <= '0;
      ltask_o <= '0;
      lver_o  <= '0;
    end else begin
      start_o <= 1'b0;
      if (accept) begin
        case (addr_i)
          A_CTRL: if (wdata_i[1:0] != 2'd0) begin
            start_o <= 1'b1;
            cmd_o   <= cmd_e'(wdata_i[1:0]);
          end
          A_SLOT:  slot_o  <= wdata_i[SLOT_W-1:0];
          A_STASK: stask_o <= wdata_i[TASK_W-1:0];
          A_SVER:  sver_o  <= wdata_i[VER_W-1:0];
          A_LTASK: ltask_o <= wdata_i[TASK_W-1:0];
          A_LVER:  lver_o  <= wdata_i[VER_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SLOT:  rdata_o[SLOT_W-1:0] = slot_o;
      A_STASK: rdata_o[TASK_W-1:0] = stask_o;
      A_SVER:  rdata_o[VER_W-1:0]  = sver_o;
      A_LTASK: rdata_o[TASK_W-1:0] = ltask_o;
      A_LVER:  rdata_o[VER_W-1:0]  = lver_o;
      A_STAT:  rdata_o[STAT_W-1:0] = status_i;
      A_INFO:  rdata_o[INFO_W-1:0] = info_i;
      default: rdata_o = '0;
    endcase
  end

  // start only fires from an idle sequencer
  p_start_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_i);
endmodule

// File: rtl/ctx_cache.sv
`timescale 1ns/1ps
module ctx_cache #(
  parameter int SLOTS     = 3,
  parameter int CHAIN_LEN = 16,
  parameter int TASK_W    = 4,
  parameter int VER_W     = 4,
  parameter int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [SLOT_W-1:0]    wr_idx_i,
  input  logic [TASK_W-1:0]    wr_task_i,
  input  logic [VER_W-1:0]     wr_ver_i,
  input  logic [CHAIN_LEN-1:0] wr_data_i,
  input  logic                 clean_en_i,
  input  logic [SLOT_W-1:0]    clean_idx_i,
  input  logic [TASK_W-1:0]    lk_task_i,
  input  logic [VER_W-1:0]     lk_ver_i,
  output logic                 hit_o,
  output logic                 task_seen_o,
  output logic [CHAIN_LEN-1:0] hit_data_o,
  input  logic [SLOT_W-1:0]    rd_idx_i,
  output logic                 rd_valid_o,
  output logic                 rd_dirty_o,
  output logic [TASK_W-1:0]    rd_task_o,
  output logic [VER_W-1:0]     rd_ver_o
);
  logic [SLOTS-1:0]     valid_q, dirty_q, task_m, hit_m;
  logic [TASK_W-1:0]    task_q [SLOTS];
  logic [VER_W-1:0]     ver_q  [SLOTS];
  logic [CHAIN_LEN-1:0] data_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        task_q[g]  <= '0;
        ver_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (wr_en_i && (int'(wr_idx_i) == g)) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= 1'b1;
        task_q[g]  <= wr_task_i;
        ver_q[g]   <= wr_ver_i;
        data_q[g]  <= wr_data_i;
      end else if (clean_en_i && (int'(clean_idx_i) == g)) begin
        dirty_q[g] <= 1'b0;
      end
    end
    assign task_m[g] = valid_q[g] && (task_q[g] == lk_task_i);
    assign hit_m[g]  = task_m[g] && (ver_q[g] == lk_ver_i);
  end

  // lowest hitting slot wins
  always_comb begin
    hit_data_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hit_m[i]) hit_data_o = data_q[i];
    end
  end
  assign hit_o       = |hit_m;
  assign task_seen_o = |task_m;

  always_comb begin
    rd_valid_o = 1'b0;
    rd_dirty_o = 1'b0;
    rd_task_o  = '0;
    rd_ver_o   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (int'(rd_idx_i) == i) begin
        rd_valid_o = valid_q[i];
        rd_dirty_o = dirty_q[i];
        rd_task_o  = task_q[i];
        rd_ver_o   = ver_q[i];
      end
    end
  end

  p_wr_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_idx_i) < SLOTS));
  p_clean_dirty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_en_i |-> (dirty_q[clean_idx_i] && valid_q[clean_idx_i]));
  p_clean_after_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean_en_i && !wr_en_i) |=> !dirty_q[$past(clean_idx_i)]);
endmodule

// File: rtl/ctx_seq.sv
`timescale 1ns/1ps
module ctx_seq
  import ctx_pkg::*;
#(
  parameter int SLOTS     = 3,
  parameter int CHAIN_LEN = 16,
  parameter int SLOT_W    = 2,
  parameter int CNT_W     = $clog2(CHAIN_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  cmd_e                 cmd_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic                 hit_i,
  input  logic                 task_seen_i,
  input  logic [CHAIN_LEN-1:0] hit_data_i,
  input  logic                 scan_out_i,
  input  logic                 wt_ack_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 verr_o,
  output logic                 miss_o,
  output logic                 wt_busy_o,
  output logic                 scan_shift_o,
  output logic                 scan_in_o,
  output logic                 swap_o,
  output logic                 wr_en_o,
  output logic [CHAIN_LEN-1:0] wr_data_o,
  output logic                 clean_en_o,
  output logic                 wt_req_o,
  output logic [CHAIN_LEN-1:0] wt_data_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

  seq_st_e              state_q;
  cmd_e                 cmd_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CHAIN_LEN-1:0] sh_q;
  logic                 last;
  logic                 slot_bad;

  assign last     = (cnt_q == LAST);
  assign slot_bad = (int'(slot_i) >= SLOTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= CMD_NONE;
      cnt_q   <= '0;
      sh_q    <= '0;
      done_o  <= 1'b0;
      verr_o  <= 1'b0;
      miss_o  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          done_o <= 1'b0;
          verr_o <= 1'b0;
          miss_o <= 1'b0;
          cmd_q  <= cmd_i;
          cnt_q  <= '0;
          if ((cmd_i != CMD_LOAD) && slot_bad) begin
            miss_o <= 1'b1;
            done_o <= 1'b1;
          end else if (cmd_i == CMD_SAVE) begin
            state_q <= S_OUT;
          end else begin
            state_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (hit_i) begin
            sh_q    <= hit_data_i;
            state_q <= S_IN;
          end else begin
            verr_o  <= task_seen_i;
            miss_o  <= !task_seen_i;
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_IN: begin
          sh_q  <= sh_q >> 1;
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) state_q <= S_SWAP;
        end
        S_SWAP: begin
          if (cmd_q == CMD_SWITCH) begin
            state_q <= S_OUT;
          end else begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_OUT: begin
          sh_q  <= {scan_out_i, sh_q[CHAIN_LEN-1:1]};
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) state_q <= S_WT;
        end
        S_WT: if (wt_ack_i) begin
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign wt_busy_o    = (state_q == S_WT);
  assign scan_shift_o = (state_q == S_IN) || (state_q == S_OUT);
  assign scan_in_o    = (state_q == S_IN) && sh_q[0];
  assign swap_o       = (state_q == S_SWAP);
  assign wr_en_o      = (state_q == S_OUT) && last;
  assign wr_data_o    = {scan_out_i, sh_q[CHAIN_LEN-1:1]};
  assign wt_req_o     = (state_q == S_WT);
  assign wt_data_o    = sh_q;
  assign clean_en_o   = (state_q == S_WT) && wt_ack_i;

  p_wt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wt_req_o && !wt_ack_i) |=> (wt_req_o && $stable(wt_data_o)));
  p_swap_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_o |=> !swap_o);
  p_fail_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOOK && !hit_i) |=> (!scan_shift_o && !swap_o && !wt_req_o));
  p_done_no_wt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !wt_req_o);
  p_flags_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(verr_o && miss_o));
endmodule

// File: rtl/ctx_col_ctrl.sv
`timescale 1ns/1ps
module ctx_col_ctrl
  import ctx_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int CHAIN_LEN = 16,
  parameter int SLOTS     = 3,
  parameter int TASK_W    = 4,
  parameter int VER_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic [2:0]           bus_addr_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  output logic                 scan_shift_o,
  output logic                 scan_in_o,
  input  logic                 scan_out_i,
  output logic                 swap_req_o,
  output logic                 wt_req_o,
  output logic [TASK_W-1:0]    wt_task_o,
  output logic [VER_W-1:0]     wt_ver_o,
  output logic [CHAIN_LEN-1:0] wt_data_o,
  input  logic                 wt_ack_i
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int INFO_W = TASK_W + VER_W + 2;

  logic                 start, busy, done, verr, miss, wt_busy;
  cmd_e                 cmd;
  logic [SLOT_W-1:0]    slot;
  logic [TASK_W-1:0]    stask, ltask;
  logic [VER_W-1:0]     sver, lver;
  logic                 hit, task_seen, wr_en, clean_en;
  logic [CHAIN_LEN-1:0] hit_data, wr_data;
  logic                 rd_valid, rd_dirty;
  logic [TASK_W-1:0]    rd_task;
  logic [VER_W-1:0]     rd_ver;
  logic [STAT_W-1:0]    status;
  logic [INFO_W-1:0]    info;

  assign status = {wt_busy, miss, verr, done, busy | start};
  assign info   = {rd_dirty, rd_valid, rd_task, rd_ver};

  ctx_regs #(
    .BUS_W(BUS_W), .TASK_W(TASK_W), .VER_W(VER_W), .SLOT_W(SLOT_W), .INFO_W(INFO_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .busy_i(busy), .status_i(status), .info_i(info), .rdata_o(bus_rdata_o),
    .start_o(start), .cmd_o(cmd), .slot_o(slot),
    .stask_o(stask), .sver_o(sver), .ltask_o(ltask), .lver_o(lver)
  );

  ctx_cache #(
    .SLOTS(SLOTS), .CHAIN_LEN(CHAIN_LEN), .TASK_W(TASK_W), .VER_W(VER_W), .SLOT_W(SLOT_W)
  ) u_cache (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(slot), .wr_task_i(stask), .wr_ver_i(sver),
    .wr_data_i(wr_data), .clean_en_i(clean_en), .clean_idx_i(slot),
    .lk_task_i(ltask), .lk_ver_i(lver),
    .hit_o(hit), .task_seen_o(task_seen), .hit_data_o(hit_data),
    .rd_idx_i(slot), .rd_valid_o(rd_valid), .rd_dirty_o(rd_dirty),
    .rd_task_o(rd_task), .rd_ver_o(rd_ver)
  );

  ctx_seq #(
    .SLOTS(SLOTS), .CHAIN_LEN(CHAIN_LEN), .SLOT_W(SLOT_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .cmd_i(cmd), .slot_i(slot),
    .hit_i(hit), .task_seen_i(task_seen), .hit_data_i(hit_data),
    .scan_out_i, .wt_ack_i,
    .busy_o(busy), .done_o(done), .verr_o(verr), .miss_o(miss), .wt_busy_o(wt_busy),
    .scan_shift_o, .scan_in_o, .swap_o(swap_req_o),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .clean_en_o(clean_en),
    .wt_req_o, .wt_data_o
  );

  assign wt_task_o = stask;
  assign wt_ver_o  = sver;

  p_wt_tag_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wt_req_o && !wt_ack_i) |=> ($stable(wt_task_o) && $stable(wt_ver_o)));
  p_swap_no_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(swap_req_o && scan_shift_o));
endmodule

// File: tb/ctx_col_ctrl_test.sv
`timescale 1ns/1ps
module ctx_col_ctrl_test;
  localparam int N = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_we_i = 1'b0;
  logic [2:0] bus_addr_i = 3'd6;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic scan_shift_o, scan_in_o, scan_out_i, swap_req_o, wt_req_o;
  logic [3:0] wt_task_o, wt_ver_o;
  logic [N-1:0] wt_data_o;
  logic wt_ack_i = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  ctx_col_ctrl uut (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .scan_shift_o, .scan_in_o, .scan_out_i, .swap_req_o,
    .wt_req_o, .wt_task_o, .wt_ver_o, .wt_data_o, .wt_ack_i
  );

  // fabric model: hidden chain and active plane
  logic [N-1:0] hidden = '0, active = '0, p_hidden = '0, p_active = '0;
  logic preset_en = 1'b0;
  int shift_cnt = 0, swap_cnt = 0;
  assign scan_out_i = hidden[0];

  always @(posedge clk_i) begin
    if (preset_en) begin
      hidden <= p_hidden;
      active <= p_active;
    end else begin
      if (scan_shift_o) begin
        hidden <= {scan_in_o, hidden[N-1:1]};
        shift_cnt <= shift_cnt + 1;
      end
      if (swap_req_o) begin
        hidden <= active;
        active <= hidden;
        swap_cnt <= swap_cnt + 1;
      end
    end
  end

  // central store responder
  int wt_delay = 3, wt_wait = 0, wt_cnt = 0;
  logic [N-1:0] wt_seen_data = '0;
  logic [3:0] wt_seen_task = '0, wt_seen_ver = '0;
  always @(posedge clk_i) begin
    wt_ack_i <= 1'b0;
    if (wt_req_o && !wt_ack_i) begin
      if (wt_wait >= wt_delay) begin
        wt_ack_i <= 1'b1;
        wt_wait <= 0;
        wt_cnt <= wt_cnt + 1;
        wt_seen_data <= wt_data_o;
        wt_seen_task <= wt_task_o;
        wt_seen_ver <= wt_ver_o;
      end else begin
        wt_wait <= wt_wait + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    bus_wdata_i = d;
    bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
    bus_addr_i = 3'd6;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_addr_i = 3'd6;
  endtask

  task automatic preset(input logic [N-1:0] h, input logic [N-1:0] a);
    @(negedge clk_i);
    p_hidden = h;
    p_active = a;
    preset_en = 1'b1;
    @(negedge clk_i);
    preset_en = 1'b0;
  endtask

  task automatic setup(input int slot, input int st, input int sv, input int lt, input int lv);
    wr(3'd1, 16'(slot));
    wr(3'd2, 16'(st));
    wr(3'd3, 16'(sv));
    wr(3'd4, 16'(lt));
    wr(3'd5, 16'(lv));
  endtask

  // waits for completion; returns final status and slot info seen at first write-through
  task automatic wait_done(output logic [15:0] st, output logic [15:0] mid_info);
    bit saw = 0;
    mid_info = '0;
    st = '0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (wt_req_o && !saw) begin
        bus_addr_i = 3'd7;
        #1 mid_info = bus_rdata_o;
        saw = 1;
      end
      bus_addr_i = 3'd6;
      #1 st = bus_rdata_o;
      if (!st[0] && st[1]) break;
    end
  endtask

  task automatic run(input int cmd, output logic [15:0] st, output logic [15:0] mid_info);
    wr(3'd0, 16'(cmd));
    wait_done(st, mid_info);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(3'd6, d); chk("R1 status", d, 0);
    for (int s = 0; s < 3; s++) begin
      wr(3'd1, 16'(s));
      rd(3'd7, d); chk("R1 slot info", d, 0);
    end
    chk("R1 outputs", {scan_shift_o, swap_req_o, wt_req_o}, 0);
  endtask

  task automatic t_save;
    logic [15:0] st, mid, d;
    int s0, w0;
    wt_delay = 5;
    preset(16'hA5C3, 16'h0000);
    setup(0, 3, 1, 0, 0);
    s0 = shift_cnt; w0 = wt_cnt;
    run(2, st, mid);
    chk("R6 save status", st, 16'h02);
    chk("R6 shift count", shift_cnt - s0, N);
    chk("R7 dirty while pending", mid[9], 1);
    chk("R7 one push", wt_cnt - w0, 1);
    chk("R7 pushed data", wt_seen_data, 16'hA5C3);
    chk("R7 pushed tags", {wt_seen_task, wt_seen_ver}, 8'h31);
    rd(3'd7, d); chk("R6 slot info clean", d, 16'h131);
  endtask

  task automatic t_restore;
    logic [15:0] st, mid;
    int s0, w0;
    preset(16'hFFFF, 16'h0000);
    setup(0, 3, 1, 3, 1);
    s0 = shift_cnt; w0 = swap_cnt;
    run(1, st, mid);
    chk("R3 restore status", st, 16'h02);
    chk("R3 shift count", shift_cnt - s0, N);
    chk("R3 swap count", swap_cnt - w0, 1);
    chk("R3 active plane", active, 16'hA5C3);
  endtask

  task automatic t_verr;
    logic [15:0] st, mid;
    int s0, w0;
    preset(16'h2222, 16'h1111);
    setup(0, 3, 1, 3, 2);
    s0 = shift_cnt; w0 = swap_cnt;
    run(1, st, mid);
    chk("R4 ver_err status", st, 16'h06);
    chk("R4 no shift/swap", (shift_cnt - s0) + (swap_cnt - w0), 0);
    chk("R4 active kept", active, 16'h1111);
  endtask

  task automatic t_miss;
    logic [15:0] st, mid;
    int s0, w0;
    setup(0, 3, 1, 9, 1);
    s0 = shift_cnt; w0 = swap_cnt;
    run(1, st, mid);
    chk("R5 miss status", st, 16'h0A);
    chk("R5 no shift/swap", (shift_cnt - s0) + (swap_cnt - w0), 0);
  endtask

  task automatic t_bad_slot;
    logic [15:0] st, mid, d;
    int s0, w0;
    setup(3, 6, 6, 3, 1);
    s0 = shift_cnt; w0 = wt_cnt;
    run(2, st, mid);
    chk("R10 save refused", st, 16'h0A);
    chk("R10 nothing moved", (shift_cnt - s0) + (wt_cnt - w0), 0);
    run(3, st, mid);
    chk("R10 switch refused", st, 16'h0A);
    chk("R10 switch nothing moved", (shift_cnt - s0) + (wt_cnt - w0), 0);
    wr(3'd1, 16'd0);
    rd(3'd7, d); chk("R10 slot0 intact", d, 16'h131);
  endtask

  task automatic t_stale;
    logic [15:0] st, mid;
    wt_delay = 2;
    preset(16'h0F0F, 16'h0000);
    setup(0, 3, 2, 3, 1);
    run(2, st, mid);
    chk("R6 resave status", st, 16'h02);
    run(1, st, mid);
    chk("R4 stale copy refused", st, 16'h06);
    wr(3'd5, 16'd2);
    run(1, st, mid);
    chk("R3 current copy restored", active, 16'h0F0F);
  endtask

  task automatic t_switch;
    logic [15:0] st, mid, d;
    int s0, w0, p0;
    preset(16'h3C3C, 16'h0000);
    setup(1, 5, 2, 0, 0);
    run(2, st, mid);
    preset(16'h0000, 16'hBEEF);
    setup(2, 7, 4, 5, 2);
    s0 = shift_cnt; w0 = swap_cnt; p0 = wt_cnt;
    run(3, st, mid);
    chk("R8 switch status", st, 16'h02);
    chk("R8 shift count", shift_cnt - s0, 2 * N);
    chk("R8 swap count", swap_cnt - w0, 1);
    chk("R8 incoming live", active, 16'h3C3C);
    chk("R8 outgoing pushed", wt_seen_data, 16'hBEEF);
    chk("R8 push count", wt_cnt - p0, 1);
    rd(3'd7, d); chk("R8 slot2 info", d, 16'h174);
  endtask

  task automatic t_switch_fail;
    logic [15:0] st, mid, d;
    int s0, w0, p0;
    setup(2, 8, 8, 11, 1);
    s0 = shift_cnt; w0 = swap_cnt; p0 = wt_cnt;
    run(3, st, mid);
    chk("R9 switch miss status", st, 16'h0A);
    chk("R9 nothing moved", (shift_cnt - s0) + (swap_cnt - w0) + (wt_cnt - p0), 0);
    rd(3'd7, d); chk("R9 slot2 intact", d, 16'h174);
  endtask

  task automatic t_lock;
    logic [15:0] st, mid, d;
    int p0;
    wt_delay = 20;
    preset(16'h1234, 16'h0000);
    setup(2, 7, 5, 0, 0);
    p0 = wt_cnt;
    wr(3'd0, 16'd2);
    wr(3'd2, 16'd9);
    wr(3'd0, 16'd1);
    wait_done(st, mid);
    chk("R2 lock status", st, 16'h02);
    rd(3'd2, d); chk("R2 write while busy ignored", d, 16'd7);
    chk("R2 only one push", wt_cnt - p0, 1);
    chk("R7 tags of push", {wt_seen_task, wt_seen_ver}, 8'h75);
    rd(3'd7, d); chk("R6 slot2 updated", d, 16'h175);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_save;
    t_restore;
    t_verr;
    t_miss;
    t_bad_slot;
    t_stale;
    t_switch;
    t_switch_fail;
    t_lock;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule